// File: doc/BRIEF.md
# NAND Page Reed-Solomon Parity Engine

This block computes a shortened Reed-Solomon code over GF(2^10) across one NAND page while the page bytes stream past it, one byte per clock. Host software sets it up through a small register interface. For a page program it sets generate mode and streams the page, then reads back eight parity bytes and stores them in the spare area. For a page read it sets check mode and streams the page followed by the eight stored parity bytes. It then reads a single pass/fail flag. The host runs its own decoder only when that flag reports a mismatch.

Each byte is complemented before it enters the encoder. A blank (all-0xFF) page therefore encodes to zero parity, and its complemented readout is all ones. The six 10-bit parity symbols are packed into eight bytes with a fixed layout that straddles byte boundaries. Each byte appears in the low half of a 16-bit register, in a true form and in a complemented form.

Top module: `rs_page_ecc`

## Requirements
- R1: The true parity symbols s0..s5 are the coefficients of x^0..x^5 of the remainder of D(x)·x^6 modulo g(x). Here g(x) = (x+1)(x+a)(x+a^2)(x+a^3)(x+a^4)(x+a^5) over GF(2^10) with field polynomial x^10+x^3+1, and a = x. D(x) takes the first encoded byte as its highest-degree coefficient.
- R2: Each data byte b enters the encoder as the 10-bit symbol {2'b00, ~b}. An all-0xFF page yields zero true parity and complemented readout bytes that are all 0xFF.
- R3: The control register is at address 0. A write with bit 7 set clears the parity, the byte count and the error flag. Bit 6 selects generate mode when 1 and check mode when 0. Bit 5 enables the byte feed. A read returns bits 6 and 5 as last written, and bit 7 reads 0.
- R4: While bit 5 of the control register is 0, byte_valid is ignored and the parity and the error flag stay unchanged.
- R5: Addresses 8..15 read true parity bytes 0..7 in bits [7:0], with bits [15:8] zero. Byte0 holds s5[7:0]. Byte1 is {s4[5:0], s5[9:8]}. Byte2 is {s3[3:0], s4[9:6]}. Byte3 is {s2[1:0], s3[9:4]}. Byte4 is s2[9:2]. Byte5 is s1[7:0]. Byte6 is {s0[5:0], s1[9:8]}. Byte7 is {4'hF, s0[9:6]}.
- R6: Addresses 16..23 read the bitwise complement of the R5 bytes. The exception is bits [7:4] of byte 7, which read 1 in both forms.
- R7: After a clear, only the first DATA_BYTES (512) accepted bytes are encoded. In generate mode, further bytes are ignored.
- R8: In check mode, the 8 bytes accepted after the data are taken as stored parity in the complemented form of R6. Bit 7 of the check register at address 1 reads 1 when any of the 60 symbol bits differ from the recomputed parity, and 0 when all of them match. Bits [7:4] of the eighth stored byte are ignored. The flag is readable in the cycle after the last stored byte is accepted.
- R9: The error flag holds until a clearing control write. Bytes beyond the stored parity, and control writes without bit 7, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| byte_valid | input | 1 | Page byte present on byte_in this cycle |
| byte_in | input | 8 | Page byte stream |

## Verification
On every cycle, the assertions check that the byte count never runs past the data plus the stored parity. They also check that a clearing write empties the parity, the count and the flag, and that a disabled feed freezes the state. Two more properties hold the error flag until a clear and stop the count at the page end in generate mode. The parity values themselves, the straddling byte layout, the complemented readout, and whether a single corrupted data or parity byte raises the flag can only be shown by the bench's scenarios. Those scenarios compare against a long-division model of the code.

// File: rtl/rs_page_ecc.sv
module rs_page_ecc #(
  parameter int DATA_BYTES = 512,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              byte_valid,
  input  logic [7:0]        byte_in
);
  localparam int SW = 10;
  localparam int NP = 6;
  localparam int CW = $clog2(DATA_BYTES + 9);
  localparam logic [CW-1:0] N_DATA = CW'(DATA_BYTES);
  localparam logic [CW-1:0] N_LAST = CW'(DATA_BYTES + 7);
  localparam logic [CW-1:0] N_END  = CW'(DATA_BYTES + 8);

  function automatic logic [SW-1:0] gf_mul(input logic [SW-1:0] a, input logic [SW-1:0] b);
    logic [SW-1:0] p;
    logic [SW-1:0] x;
    p = '0;
    x = a;
    for (int i = 0; i < SW; i++) begin
      if (b[i]) p = p ^ x;
      x = x[SW-1] ? ((x << 1) ^ 10'h009) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [SW*NP-1:0] gen_poly();
    logic [SW*(NP+1)-1:0] g;
    logic [SW-1:0] root;
    g = '0;
    g[SW-1:0] = 10'd1;
    root = 10'd1;
    for (int i = 0; i < NP; i++) begin
      for (int k = i + 1; k >= 1; k--)
        g[k*SW +: SW] = g[(k-1)*SW +: SW] ^ gf_mul(g[k*SW +: SW], root);
      g[SW-1:0] = gf_mul(g[SW-1:0], root);
      root = gf_mul(root, 10'd2);
    end
    return g[SW*NP-1:0];
  endfunction

  localparam logic [SW*NP-1:0] GEN = gen_poly();

  logic [SW*NP-1:0] par, par_nx;
  logic [CW-1:0]    cnt;
  logic [55:0]      stash;
  logic             mode_gen, feed_en, err;

  wire ctrl_wr  = reg_we && reg_addr == '0;
  wire clr      = ctrl_wr && reg_wdata[7];
  wire take     = feed_en && byte_valid;
  wire in_data  = take && cnt < N_DATA;
  wire in_par   = take && !mode_gen && cnt >= N_DATA && cnt < N_END;
  wire last_par = in_par && cnt == N_LAST;
  wire [2:0] pidx = 3'(cnt - N_DATA);

  wire [SW-1:0] fb = {2'b00, ~byte_in} ^ par[SW*NP-1 -: SW];

  for (genvar k = 0; k < NP; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign par_nx[SW-1:0] = gf_mul(fb, GEN[SW-1:0]);
    end else begin : g_rest
      assign par_nx[k*SW +: SW] = par[(k-1)*SW +: SW] ^ gf_mul(fb, GEN[k*SW +: SW]);
    end
  end

  // stored bytes as they stand once the last one arrives
  wire [63:0] st = {byte_in, stash};
  wire [SW*NP-1:0] rx = ~{ {st[11:8],  st[7:0]},   {st[19:16], st[15:10]},
                           {st[29:24], st[23:20]}, {st[39:32], st[31:30]},
                           {st[49:48], st[47:40]}, {st[59:56], st[55:50]} };
  wire mismatch = rx != par;

  wire [9:0] s0 = par[9:0],   s1 = par[19:10], s2 = par[29:20];
  wire [9:0] s3 = par[39:30], s4 = par[49:40], s5 = par[59:50];
  wire [63:0] pk = { {4'hF, s0[9:6]}, {s0[5:0], s1[9:8]}, s1[7:0], s2[9:2],
                     {s2[1:0], s3[9:4]}, {s3[3:0], s4[9:6]}, {s4[5:0], s5[9:8]}, s5[7:0] };

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par <= '0; cnt <= '0; stash <= '0; err <= 1'b0;
      mode_gen <= 1'b0; feed_en <= 1'b0;
    end else if (ctrl_wr) begin
      mode_gen <= reg_wdata[6];
      feed_en  <= reg_wdata[5];
      if (reg_wdata[7]) begin
        par <= '0; cnt <= '0; stash <= '0; err <= 1'b0;
      end
    end else begin
      if (in_data) begin
        par <= par_nx;
        cnt <= cnt + 1'b1;
      end
      if (in_par) begin
        cnt <= cnt + 1'b1;
        if (!last_par) stash[pidx*8 +: 8] <= byte_in;
      end
      if (last_par) err <= mismatch;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata[6:5] = {mode_gen, feed_en};
    else if (reg_addr == ADDR_W'(1)) reg_rdata[7] = err;
    else if (reg_addr >= ADDR_W'(8) && reg_addr < ADDR_W'(16))
      reg_rdata[7:0] = pk[reg_addr[2:0]*8 +: 8];
    else if (reg_addr >= ADDR_W'(16) && reg_addr < ADDR_W'(24))
      reg_rdata[7:0] = pk[reg_addr[2:0]*8 +: 8] ^ ((reg_addr[2:0] == 3'd7) ? 8'h0F : 8'hFF);
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= N_END);
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && par == '0 && !err));
  a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed_en && !ctrl_wr) |=> ($stable(par) && $stable(cnt) && $stable(err)));
  a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);
  a_r7_gen_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_gen && cnt == N_DATA && !ctrl_wr) |=> (cnt == N_DATA && $stable(par)));
endmodule

// File: tb/sim_rs_page_ecc.sv
module sim_rs_page_ecc;
  localparam int NB = 512;
  logic clk = 0, rst_n = 0, reg_we = 0, byte_valid = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, byte_in = 0;
  logic [15:0] reg_rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  rs_page_ecc u0 (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .byte_valid, .byte_in);

  always #5 clk = ~clk;

  logic [15:0] exp_q[$];
  string tag_q[$];
  logic [7:0] page [NB];
  logic [7:0] etrue [8];
  logic [7:0] einv [8];
  logic [9:0] gco [7];

  always @(negedge clk) if (exp_q.size() > 0) begin
    logic [15:0] e;
    string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", t, reg_addr, reg_rdata, e);
    end
  end

  function automatic logic [9:0] mul(input logic [9:0] a, input logic [9:0] b);
    logic [19:0] p;
    p = '0;
    for (int i = 0; i < 10; i++) if (b[i]) p = p ^ (20'(a) << i);
    for (int d = 19; d >= 10; d--) if (p[d]) p = p ^ (20'h409 << (d - 10));
    return p[9:0];
  endfunction

  task automatic build_gen();
    logic [9:0] r;
    for (int k = 0; k < 7; k++) gco[k] = 0;
    gco[0] = 1; r = 1;
    for (int i = 0; i < 6; i++) begin
      for (int k = 6; k >= 1; k--) gco[k] = gco[k-1] ^ mul(gco[k], r);
      gco[0] = mul(gco[0], r);
      r = mul(r, 10'd2);
    end
  endtask

  task automatic model();
    logic [9:0] c [NB+6];
    logic [9:0] s [6];
    logic [9:0] q;
    for (int i = 0; i < NB; i++) c[NB+5-i] = {2'b00, ~page[i]};
    for (int i = 0; i < 6; i++) c[i] = 0;
    for (int d = NB + 5; d >= 6; d--) begin
      q = c[d];
      for (int k = 0; k <= 6; k++) c[d-6+k] = c[d-6+k] ^ mul(q, gco[k]);
    end
    for (int i = 0; i < 6; i++) s[i] = c[i];
    etrue[0] = s[5][7:0];               etrue[1] = {s[4][5:0], s[5][9:8]};
    etrue[2] = {s[3][3:0], s[4][9:6]};  etrue[3] = {s[2][1:0], s[3][9:4]};
    etrue[4] = s[2][9:2];               etrue[5] = s[1][7:0];
    etrue[6] = {s[0][5:0], s[1][9:8]};  etrue[7] = {4'hF, s[0][9:6]};
    for (int j = 0; j < 7; j++) einv[j] = ~etrue[j];
    einv[7] = {4'hF, ~etrue[7][3:0]};
  endtask

  task automatic wr(input logic [7:0] v);
    @(posedge clk); #1 reg_we = 1; reg_addr = 0; reg_wdata = v;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string t);
    @(posedge clk); #1 reg_addr = a; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic feed(input logic [7:0] b);
    @(posedge clk); #1 byte_valid = 1; byte_in = b;
  endtask

  task automatic feed_end();
    @(posedge clk); #1 byte_valid = 0;
  endtask

  task automatic send_page();
    for (int i = 0; i < NB; i++) feed(page[i]);
  endtask

  task automatic check_parity(input string t);
    for (int j = 0; j < 8; j++) rd(5'(8 + j), {8'h00, etrue[j]}, t);
    for (int j = 0; j < 8; j++) rd(5'(16 + j), {8'h00, einv[j]}, t);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    build_gen();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R3 R5 R6 reset state
    rd(0, 16'h0000, "R3 reset ctrl");
    rd(1, 16'h0000, "R8 reset check");
    rd(8, 16'h0000, "R5 reset byte0");
    rd(15, 16'h00F0, "R5 reset byte7");
    rd(16, 16'h00FF, "R6 reset inv byte0");
    rd(23, 16'h00FF, "R6 reset inv byte7");

    // R4: bytes before enable ignored
    for (int i = 0; i < 4; i++) feed(8'h5A);
    feed_end();
    rd(8, 16'h0000, "R4 feed disabled");

    // R2 blank page
    for (int i = 0; i < NB; i++) page[i] = 8'hFF;
    model();
    wr(8'hE0);
    rd(0, 16'h0060, "R3 ctrl readback");
    send_page(); feed_end();
    check_parity("R2 blank page");

    // R1 R5 R6 R7 R4 pattern A
    for (int i = 0; i < NB; i++) page[i] = 8'((i * 37 + 11) ^ (i >> 4));
    model();
    wr(8'hE0);
    send_page();
    for (int i = 0; i < 3; i++) feed(8'h33);
    feed_end();
    check_parity("R7 extra bytes ignored / R1 pattern A");
    wr(8'h00);
    rd(0, 16'h0000, "R3 ctrl zero");
    for (int i = 0; i < 5; i++) feed(8'hC3);
    feed_end();
    check_parity("R4 frozen");

    // R8 clean read
    wr(8'hA0);
    rd(0, 16'h0020, "R3 read mode readback");
    send_page();
    for (int j = 0; j < 8; j++) feed(einv[j]);
    feed_end();
    rd(1, 16'h0000, "R8 clean page");
    check_parity("R1 read mode parity");

    // R8 corrupted data byte, R9 hold
    wr(8'hA0);
    for (int i = 0; i < NB; i++) feed(i == 100 ? page[i] ^ 8'h04 : page[i]);
    for (int j = 0; j < 8; j++) feed(einv[j]);
    feed_end();
    rd(1, 16'h0080, "R8 data error");
    for (int i = 0; i < 6; i++) feed(8'h00);
    feed_end();
    rd(1, 16'h0080, "R9 hold after extra bytes");
    wr(8'h20);
    rd(1, 16'h0080, "R9 hold after non-clear write");
    wr(8'h80);
    rd(1, 16'h0000, "R3 clear drops flag");
    rd(8, 16'h0000, "R3 clear zeroes parity");

    // R8 unused nibble ignored, then parity bit error
    wr(8'hA0);
    send_page();
    for (int j = 0; j < 8; j++) feed(j == 7 ? (einv[j] & 8'h0F) : einv[j]);
    feed_end();
    rd(1, 16'h0000, "R8 unused nibble ignored");
    wr(8'hA0);
    send_page();
    for (int j = 0; j < 8; j++) feed(j == 3 ? (einv[j] ^ 8'h40) : einv[j]);
    feed_end();
    rd(1, 16'h0080, "R8 stored parity error");

    // R1 pattern B
    for (int i = 0; i < NB; i++) page[i] = 8'(i ^ (i >> 3) ^ 8'h96);
    model();
    wr(8'hE0);
    send_page(); feed_end();
    check_parity("R1 pattern B");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule